// File: doc/BRIEF.md
# Character Grid Raster Position Generator

This block places a 30-column by 12-row text overlay on a raster. It counts pixel clocks from each horizontal sync strobe and counts scan lines from each vertical sync strobe. From these counts it derives which text cell the beam is in, and which dot column and dot row inside that 12 by 18 dot glyph. A font lookup and a video mixer downstream use these outputs to draw the character dots. Everything here runs on the pixel clock.

Software positions the overlay with two 6-bit origin fields. It magnifies the glyphs with 2-bit size codes. The top text row has its own horizontal and vertical size codes, and the other eleven rows share a second pair. A wipe effect reveals or hides the text one row at a time from the top down. Each step of the wipe lasts a whole number of fields. A display enable blanks the overlay at once.

Top module: `osd_cell_locator`

## Requirements
- R1: After reset, `active`, `row`, `col`, `dot_x` and `dot_y` are all zero.
- R2: Pixel index 0 is the clock cycle that follows the cycle in which `hsync` is high. The first active pixel of a text line has index 4*`h_origin` + 9 + c, where c is the horizontal size code of the row being drawn. No earlier pixel on the line is active.
- R3: Every clock cycle with `hsync` high opens a new line. The lines after a `vsync` strobe are numbered 1, 2, 3 and so on. The first dot row of text is drawn on line 4*`v_origin` + 1, and no earlier line shows text.
- R4: A size code c gives a factor f = c + 1 (code 0 is 1x, 1 is 2x, 2 is 3x, 3 is 4x). Let p be the pixel's offset from the first active pixel. Then `col` = p / (12f) and `dot_x` = (p mod 12f) / f. After 30 columns the line goes inactive until the next `hsync`.
- R5: Let q be the line's offset from the first text line. Row 0 spans 18*fv0 lines, where fv0 is the top row's vertical factor. Every later row spans 18*fv1 lines, where fv1 is the other rows' vertical factor. `dot_y` is the line's offset inside its row divided by that row's factor. After row 11 no more text is drawn until the next `vsync`.
- R6: Row 0 uses `hmag_top` and `vmag_top`. Rows 1 to 11 use `hmag_body` and `vmag_body`. This covers both the magnification and the horizontal start offset c.
- R7: Outside the 30 by 12 area, `active`, `row`, `col`, `dot_x` and `dot_y` are all zero.
- R8: While `disp_on` is low, `active` is low. Inside the area, `row`, `col`, `dot_x` and `dot_y` are still reported.
- R9: While `wipe_en` and `disp_on` are high, a wipe position counts `vsync` strobes. It rises by one every 2 strobes when `wipe_slow` is 0, and every 5 strobes when `wipe_slow` is 1, and it stops at 12. The position is cleared while `wipe_en` or `disp_on` is low, and in the cycle after `wipe_hide` changes.
- R10: With `wipe_en` high and `wipe_hide` 0, only rows below the wipe position are shown (row < position). With `wipe_hide` 1, only rows at or above it are shown (row >= position).
- R11: While `wipe_en` is low, every row of the area is shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Line strobe; each high cycle starts a line |
| vsync | input | 1 | Field strobe; each high cycle starts a field |
| h_origin | input | 6 | Horizontal start, 4 pixel clocks per unit |
| v_origin | input | 6 | Vertical start, 4 lines per unit |
| hmag_top | input | 2 | Horizontal size code of row 0 |
| vmag_top | input | 2 | Vertical size code of row 0 |
| hmag_body | input | 2 | Horizontal size code of rows 1 to 11 |
| vmag_body | input | 2 | Vertical size code of rows 1 to 11 |
| disp_on | input | 1 | Overlay enable |
| wipe_en | input | 1 | Enables the row-by-row wipe |
| wipe_slow | input | 1 | Selects the longer step of the wipe |
| wipe_hide | input | 1 | 0 reveals rows, 1 hides rows |
| row | output | 4 | Text row index |
| col | output | 5 | Text column index |
| dot_x | output | 4 | Dot column inside the glyph |
| dot_y | output | 5 | Dot row inside the glyph |
| active | output | 1 | High when a text dot position is shown |

## Verification
The properties assume that `hsync` and `vsync` are never high in the same cycle. They also assume that the origin and size fields stay constant across a line, so the dot and row counters step in one direction only. The stimulus respects both assumptions. It raises the field strobe for one cycle, then drives a run of line strobes, and it changes the configuration only between these probes. Each probe ends on a chosen pixel of a chosen line. The wipe position is tracked by counting the field strobes that the probes themselves emit.

// File: rtl/osd_cell_locator.sv
module osd_cell_locator #(
  parameter int COLS       = 30,
  parameter int ROWS       = 12,
  parameter int CELL_W     = 12,
  parameter int CELL_H     = 18,
  parameter int HOFS       = 9,
  parameter int FIELD_RATE = 60,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS + 1),
  localparam int XW = $clog2(CELL_W),
  localparam int YW = $clog2(CELL_H)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync,
  input  logic          vsync,
  input  logic [5:0]    h_origin,
  input  logic [5:0]    v_origin,
  input  logic [1:0]    hmag_top,
  input  logic [1:0]    vmag_top,
  input  logic [1:0]    hmag_body,
  input  logic [1:0]    vmag_body,
  input  logic          disp_on,
  input  logic          wipe_en,
  input  logic          wipe_slow,
  input  logic          wipe_hide,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col,
  output logic [XW-1:0] dot_x,
  output logic [YW-1:0] dot_y,
  output logic          active
);
  localparam int PXW  = 11;
  localparam int LNW  = 11;
  localparam int SW   = 8;
  localparam int FAST = (FIELD_RATE / 24 > 0) ? FIELD_RATE / 24 : 1;
  localparam int SLOW = (FIELD_RATE / 12 > 0) ? FIELD_RATE / 12 : 1;

  logic [PXW-1:0] px;
  logic [LNW-1:0] ln;
  logic           hact, hdone, vact, vdone;
  logic [CW-1:0]  col_q;
  logic [XW-1:0]  dx_q;
  logic [1:0]     hrep, vrep;
  logic [RW-1:0]  row_q;
  logic [YW-1:0]  dy_q;
  logic [RW-1:0]  pos;
  logic [SW-1:0]  step_cnt;
  logic           hide_q;

  wire [1:0]     hcode  = (row_q == '0) ? hmag_top : hmag_body;
  wire [1:0]     vcode  = (row_q == '0) ? vmag_top : vmag_body;
  wire [PXW-1:0] hbegin = PXW'({h_origin, 2'b00}) + PXW'(HOFS) + PXW'(hcode);
  wire [LNW-1:0] vbegin = LNW'({v_origin, 2'b00});
  wire [SW-1:0]  step_len = wipe_slow ? SW'(SLOW) : SW'(FAST);

  always_ff @(posedge clk) begin
    if (!rst_n || hsync) begin
      px <= '0; hact <= 1'b0; hdone <= 1'b0;
      col_q <= '0; dx_q <= '0; hrep <= '0;
    end else begin
      if (px != '1) px <= px + 1'b1;
      if (!hact) begin
        if (!hdone && px == hbegin - 1'b1) hact <= 1'b1;
      end else if (hrep == hcode) begin
        hrep <= '0;
        if (dx_q == XW'(CELL_W - 1)) begin
          dx_q <= '0;
          if (col_q == CW'(COLS - 1)) begin
            hact <= 1'b0; hdone <= 1'b1; col_q <= '0;
          end else col_q <= col_q + 1'b1;
        end else dx_q <= dx_q + 1'b1;
      end else hrep <= hrep + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || vsync) begin
      ln <= '0; vact <= 1'b0; vdone <= 1'b0;
      row_q <= '0; dy_q <= '0; vrep <= '0;
    end else if (hsync) begin
      if (ln != '1) ln <= ln + 1'b1;
      if (!vact) begin
        if (!vdone && ln == vbegin) vact <= 1'b1;
      end else if (vrep == vcode) begin
        vrep <= '0;
        if (dy_q == YW'(CELL_H - 1)) begin
          dy_q <= '0;
          if (row_q == RW'(ROWS - 1)) begin
            vact <= 1'b0; vdone <= 1'b1; row_q <= '0;
          end else row_q <= row_q + 1'b1;
        end else dy_q <= dy_q + 1'b1;
      end else vrep <= vrep + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0; step_cnt <= '0; hide_q <= 1'b0;
    end else begin
      hide_q <= wipe_hide;
      if (!wipe_en || !disp_on || wipe_hide != hide_q) begin
        pos <= '0; step_cnt <= '0;
      end else if (vsync) begin
        if (step_cnt >= step_len - 1'b1) begin
          step_cnt <= '0;
          if (pos != RW'(ROWS)) pos <= pos + 1'b1;
        end else step_cnt <= step_cnt + 1'b1;
      end
    end
  end

  wire in_area = hact && vact;
  wire shown   = !wipe_en || (wipe_hide ? (row_q >= pos) : (row_q < pos));

  assign active = in_area && disp_on && shown;
  assign row    = in_area ? row_q : '0;
  assign col    = in_area ? col_q : '0;
  assign dot_x  = in_area ? dx_q  : '0;
  assign dot_y  = in_area ? dy_q  : '0;
endmodule

module osd_cell_locator_chk #(
  parameter int COLS   = 30,
  parameter int ROWS   = 12,
  parameter int CELL_W = 12,
  parameter int CELL_H = 18,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS + 1),
  localparam int XW = $clog2(CELL_W),
  localparam int YW = $clog2(CELL_H)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hsync,
  input logic          active,
  input logic [RW-1:0] row,
  input logic [CW-1:0] col,
  input logic [XW-1:0] dot_x,
  input logic [YW-1:0] dot_y,
  input logic          vact,
  input logic [RW-1:0] row_q,
  input logic [RW-1:0] wipe_pos
);
  // R5 covered by the same range property
  assert_cell_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (col < CW'(COLS)) && (row < RW'(ROWS)) && (dot_x < XW'(CELL_W)) && (dot_y < YW'(CELL_H)));

  assert_line_head_dark_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> !active);

  assert_dot_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |->
      (dot_x == $past(dot_x)) || (dot_x == $past(dot_x) + 1'b1) ||
      (dot_x == '0 && $past(dot_x) == XW'(CELL_W - 1)));

  assert_row_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vact && $past(vact)) |-> (row_q == $past(row_q)) || (row_q == $past(row_q) + 1'b1));

  assert_wipe_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_pos <= RW'(ROWS));

  assert_wipe_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wipe_pos != $past(wipe_pos)) |-> (wipe_pos == '0) || (wipe_pos == $past(wipe_pos) + 1'b1));
endmodule

bind osd_cell_locator osd_cell_locator_chk #(
  .COLS(COLS), .ROWS(ROWS), .CELL_W(CELL_W), .CELL_H(CELL_H)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync(hsync), .active(active),
  .row(row), .col(col), .dot_x(dot_x), .dot_y(dot_y),
  .vact(vact), .row_q(row_q), .wipe_pos(pos)
);

// File: tb/osd_cell_locator_tb.sv
module osd_cell_locator_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync = 1'b0, vsync = 1'b0;
  logic [5:0] h_origin = '0, v_origin = '0;
  logic [1:0] hmag_top = '0, vmag_top = '0, hmag_body = '0, vmag_body = '0;
  logic disp_on = 1'b1, wipe_en = 1'b0, wipe_slow = 1'b0, wipe_hide = 1'b0;
  logic [3:0] row;
  logic [4:0] col;
  logic [3:0] dot_x;
  logic [4:0] dot_y;
  logic active;

  int checks = 0, errors = 0, fields = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  osd_cell_locator u_dut (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .h_origin(h_origin), .v_origin(v_origin),
    .hmag_top(hmag_top), .vmag_top(vmag_top),
    .hmag_body(hmag_body), .vmag_body(vmag_body),
    .disp_on(disp_on), .wipe_en(wipe_en), .wipe_slow(wipe_slow), .wipe_hide(wipe_hide),
    .row(row), .col(col), .dot_x(dot_x), .dot_y(dot_y), .active(active)
  );

  // {h_origin, v_origin, hmag_top, vmag_top, hmag_body, vmag_body, lines, pixel}
  localparam logic [43:0] VEC [13] = '{
    {6'd0,  6'd0, 2'd0, 2'd0, 2'd0, 2'd0, 12'd1,   12'd9},    // R2 first pixel
    {6'd0,  6'd0, 2'd0, 2'd0, 2'd0, 2'd0, 12'd1,   12'd8},    // R2 one early, R7 zeros
    {6'd0,  6'd0, 2'd0, 2'd0, 2'd0, 2'd0, 12'd1,   12'd368},  // R4 last column
    {6'd0,  6'd0, 2'd0, 2'd0, 2'd0, 2'd0, 12'd1,   12'd369},  // R4 past the grid, R7
    {6'd3,  6'd2, 2'd1, 2'd2, 2'd0, 2'd0, 12'd14,  12'd52},   // R6 top row 2x/3x
    {6'd3,  6'd2, 2'd1, 2'd2, 2'd0, 2'd0, 12'd63,  12'd21},   // R6 body row offset
    {6'd3,  6'd2, 2'd1, 2'd2, 2'd0, 2'd0, 12'd9,   12'd21},   // R6 top row offset
    {6'd63, 6'd0, 2'd3, 2'd3, 2'd3, 2'd3, 12'd1,   12'd1703}, // R4 4x far end
    {6'd0,  6'd0, 2'd0, 2'd0, 2'd0, 2'd0, 12'd216, 12'd9},    // R5 last dot row
    {6'd0,  6'd0, 2'd0, 2'd0, 2'd0, 2'd0, 12'd217, 12'd9},    // R5 below the grid
    {6'd0,  6'd0, 2'd0, 2'd0, 2'd0, 2'd3, 12'd240, 12'd9},    // R5 body 4x
    {6'd0,  6'd1, 2'd0, 2'd0, 2'd0, 2'd0, 12'd4,   12'd9},    // R3 line before start
    {6'd0,  6'd1, 2'd0, 2'd0, 2'd0, 2'd0, 12'd5,   12'd9}     // R3 first text line
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic probe(input int n, input int k);
    @(negedge clk) vsync = 1'b1;
    @(negedge clk) vsync = 1'b0;
    fields++;
    for (int i = 0; i < n; i++) begin
      hsync = 1'b1;
      @(negedge clk);
    end
    hsync = 1'b0;
    repeat (k) @(negedge clk);
  endtask

  task automatic field_pulses(input int m);
    for (int i = 0; i < m; i++) begin
      @(negedge clk) vsync = 1'b1;
      @(negedge clk) vsync = 1'b0;
      fields++;
    end
  endtask

  task automatic model(input int n, input int k, output int er, output int ec,
                       output int ex, output int ey, output bit ein);
    int relv, relh, fv0, fv1, hf, t, hb;
    er = 0; ec = 0; ex = 0; ey = 0; ein = 0;
    fv0 = vmag_top + 1; fv1 = vmag_body + 1;
    relv = n - 4 * v_origin - 1;
    if (relv < 0) return;
    if (relv < 18 * fv0) begin
      er = 0; ey = relv / fv0;
    end else begin
      t = relv - 18 * fv0;
      er = 1 + t / (18 * fv1);
      ey = (t % (18 * fv1)) / fv1;
    end
    if (er > 11) begin er = 0; ey = 0; return; end
    hf = (er == 0) ? hmag_top + 1 : hmag_body + 1;
    hb = 4 * h_origin + 9 + hf - 1;
    relh = k - hb;
    if (relh < 0 || relh >= 360 * hf) begin er = 0; ey = 0; return; end
    ec = relh / (12 * hf);
    ex = (relh % (12 * hf)) / hf;
    ein = 1;
  endtask

  task automatic run_probe(input int n, input int k);
    int er, ec, ex, ey, pos, step;
    bit ein, vis;
    probe(n, k);
    model(n, k, er, ec, ex, ey, ein);
    step = wipe_slow ? 5 : 2;
    pos = fields / step;
    if (pos > 12) pos = 12;
    vis = !wipe_en || (wipe_hide ? (er >= pos) : (er < pos));
    chk("R5 row", row, er);
    chk("R4 col", col, ec);
    chk("R4 dot_x", dot_x, ex);
    chk("R5 dot_y", dot_y, ey);
    chk("R2 active", active, int'(ein && disp_on && vis));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 active", active, 0);
    chk("R1 row", row, 0);
    chk("R1 col", col, 0);
    chk("R1 dot_x", dot_x, 0);
    chk("R1 dot_y", dot_y, 0);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      h_origin  = VEC[i][43:38];
      v_origin  = VEC[i][37:32];
      hmag_top  = VEC[i][31:30];
      vmag_top  = VEC[i][29:28];
      hmag_body = VEC[i][27:26];
      vmag_body = VEC[i][25:24];
      run_probe(int'(VEC[i][23:12]), int'(VEC[i][11:0]));
    end

    h_origin = '0; v_origin = '0;
    hmag_top = '0; vmag_top = '0; hmag_body = '0; vmag_body = '0;

    // R7 outside area: pixel before start, indices zero
    probe(1, 5);
    chk("R7 row", row, 0);
    chk("R7 col", col, 0);
    chk("R7 active", active, 0);

    // R8 display off keeps indices but blanks
    disp_on = 1'b0;
    probe(19, 9 + 12 * 3 + 2);
    chk("R8 active", active, 0);
    chk("R8 row", row, 1);
    chk("R8 col", col, 3);
    chk("R8 dot_x", dot_x, 2);
    disp_on = 1'b1;

    // R11 wipe disabled: last row visible
    run_probe(1 + 18 * 11, 9);

    // R9 R10 fast reveal
    @(negedge clk) begin wipe_slow = 1'b0; wipe_hide = 1'b0; wipe_en = 1'b1; end
    fields = 0;
    run_probe(1, 9);                 // R10 row 0 still hidden
    field_pulses(1);
    run_probe(1, 9);                 // R9 position 1
    run_probe(1 + 18, 9);            // R9 position 2, row 1 shown
    run_probe(1 + 36, 9);            // R10 row 2 hidden

    // R9 slow reveal
    @(negedge clk) wipe_en = 1'b0;
    @(negedge clk) begin wipe_slow = 1'b1; wipe_en = 1'b1; end
    fields = 0;
    field_pulses(9);
    run_probe(1 + 18, 9);            // R9 slow step, row 1 shown
    run_probe(1 + 36, 9);            // R9 row 2 still hidden
    field_pulses(60);
    run_probe(1 + 18 * 11, 9);       // R9 saturation at 12
    chk("R9 cap row", row, 11);

    // R10 hide direction, restart on change
    @(negedge clk) begin wipe_hide = 1'b1; wipe_slow = 1'b0; end
    fields = 0;
    run_probe(1, 9);                 // R10 row 0 shown at position 0
    field_pulses(2);
    run_probe(1, 9);                 // R10 row 0 hidden at position 2
    run_probe(1 + 36, 9);            // R10 row 2 shown

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule